// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose writer and reader run on unrelated clocks. Words enter on `wr_data` at a `wr_clk` rising edge and leave through a registered `rd_data` at an `rd_clk` rising edge. Both enables are active low. The write and read positions cross between the two clock domains as Gray codes, each through a two-flop synchronizer. Five active-low status flags report the fill state: empty, full, half-full, almost-empty and almost-full. The last two compare the fill level against two thresholds that software can program.

The thresholds travel over the normal data buses. While `ld_n` is low, a write cycle loads one threshold register instead of the storage array, and a read cycle returns one threshold on `rd_data` instead of a stored word. Each side steps through the two registers with its own small state machine. That machine has two states, `OFS_AE` and `OFS_AF`. The transition `OFS_AE -> OFS_AF` is taken on a load (or read-back) step, and the transition `OFS_AF -> OFS_AE` is taken on the next step. Reset returns the machine to `OFS_AE`.

The `sync_mode` input sets the timing of the almost flags. When it is high, almost-empty is registered on `rd_clk` and almost-full is registered on `wr_clk`. When it is low, both flags are decoded directly from the two live positions. The output enable is modelled as a valid strobe that gates the data bus.

Top module: `dcfifo_pflags`

## Requirements
- R1: At a `wr_clk` rising edge with `wr_en_n`=0, `ld_n`=1 and `full_n`=1, `wr_data` is appended. With `full_n`=0 the write is dropped, and the stored sequence is unchanged.
- R2: At an `rd_clk` rising edge with `rd_en_n`=0, `ld_n`=1 and `empty_n`=1, the oldest word is moved into the output register, so words come out in write order. With `empty_n`=0 the read is ignored and `rd_data` holds its value.
- R3: At a `wr_clk` edge with `ld_n`=0 and `wr_en_n`=0, `wr_data[ADDR_W-1:0]` is loaded into a threshold register. Successive loads go to almost-empty first, then to almost-full, and then alternate. Storage and fill level are untouched.
- R4: At an `rd_clk` edge with `ld_n`=0 and `rd_en_n`=0, `rd_data` receives the zero-extended threshold. Read-backs follow their own alternating order, which starts with almost-empty. The read position is untouched.
- R5: `empty_n` is 0 exactly when the reader-side fill is zero. `full_n` is 0 exactly when the writer-side fill equals the depth. Each flag follows its own side's transfers on the same edge, and follows the other side's transfers within three edges of its own clock.
- R6: `almost_empty_n` is 0 when fill <= almost-empty threshold. `almost_full_n` is 0 when free space <= almost-full threshold.
- R7: With `sync_mode`=1, the almost flags are registered, so a change lags the causing edge by at least three opposite-side edges. With `sync_mode`=0, they reflect both live positions just after the edge.
- R8: `half_full_n` is 0 when fill > depth/2. It is decoded from the live positions.
- R9: With `out_en_n`=1, `rd_data` is all zeros and `rd_oe` is 0. With `out_en_n`=0, `rd_oe` is 1 and `rd_data` shows the held word.
- R10: After reset the buffer is empty (`empty_n`=0, `full_n`=1, `half_full_n`=1, `almost_empty_n`=0, `almost_full_n`=1). Both thresholds are depth/8, and both sequencers point at almost-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1: registered almost flags, 0: decoded almost flags |
| ld_n | input | 1 | Active-low threshold access select |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | Write data or threshold value |
| rd_en_n | input | 1 | Active-low read enable |
| out_en_n | input | 1 | Active-low output enable |
| rd_data | output | DATA_W | Read data or threshold read-back |
| rd_oe | output | 1 | Output-valid strobe |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_full_n | output | 1 | Half-full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
Each result has its own due time:

- **Read data and threshold read-back** are valid at the `rd_clk` falling edge after the enabling rising edge. The bench compares them there.
- **Same-side flags** (`full_n` after a write, `empty_n` after a read) are checked half a cycle after the transfer.
- **Decoded flags** (`half_full_n`, and the almost flags with `sync_mode`=0) are also checked half a cycle after the transfer.
- **Registered almost flags and cross-domain flag changes** need up to three edges of the opposite clock. The bench therefore waits four edges of each clock before it compares them. Half a cycle after a write, the bench also checks that the registered almost-empty flag still shows its old value.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    // Which threshold register a load or read-back step addresses.
    typedef enum logic {
        OFS_AE = 1'b0,
        OFS_AF = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dcf_ofs_seq.sv
module dcf_ofs_seq
    import dcf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_sel_e sel
);
    ofs_sel_e state_q, state_d;

    // Next-state decode: each step moves to the other threshold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OFS_AE: if (step) state_d = OFS_AF;
            OFS_AF: if (step) state_d = OFS_AE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OFS_AE;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        sel = state_q;
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          ld_n,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   rgray_sync,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          full,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs,
    output logic          af_q
);
    localparam int            PW       = AW + 1;
    localparam int            DEPTH    = 1 << AW;
    localparam logic [AW:0]   FULL_CNT = PW'(DEPTH);
    localparam logic [AW-1:0] OFS_RST  = AW'(DEPTH / 8);

    logic [AW:0] rbin_w;
    logic [AW:0] wcnt;
    logic [AW:0] wfree;
    logic        wr_go;
    logic        ld_go;
    ofs_sel_e    ld_sel;

    // Convert the synchronized read position from Gray to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_w[i] = ^(rgray_sync >> i);
    end

    // Full when the positions match except for the two top Gray bits.
    assign full  = (wgray == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
    assign wr_go = !wr_en_n && ld_n && !full;
    assign ld_go = !wr_en_n && !ld_n;
    assign wcnt  = wbin - rbin_w;
    assign wfree = FULL_CNT - wcnt;

    assign mem_we    = wr_go;
    assign mem_waddr = wbin[AW-1:0];

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_go) begin
            wbin  <= wbin + 1'b1;
            wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
        end
    end

    dcf_ofs_seq u_ld_seq (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .step  (ld_go),
        .sel   (ld_sel)
    );

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= OFS_RST;
            af_ofs <= OFS_RST;
        end else if (ld_go) begin
            unique case (ld_sel)
                OFS_AE: ae_ofs <= wr_data[AW-1:0];
                OFS_AF: af_ofs <= wr_data[AW-1:0];
            endcase
        end
    end

    // Registered almost-full flag, in the write domain.
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) af_q <= 1'b0;
        else        af_q <= (wfree <= {1'b0, af_ofs});
    end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          ld_n,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] mem_raddr,
    output logic          empty,
    output logic          ae_q,
    output logic [DW-1:0] rd_q
);
    localparam int PW = AW + 1;

    logic [AW:0]   wbin_r;
    logic [AW:0]   rcnt;
    logic          rd_go;
    logic          rb_go;
    ofs_sel_e      rb_sel;
    logic [AW-1:0] rb_val;

    // Convert the synchronized write position from Gray to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) wbin_r[i] = ^(wgray_sync >> i);
    end

    assign empty     = (rgray == wgray_sync);
    assign rd_go     = !rd_en_n && ld_n && !empty;
    assign rb_go     = !rd_en_n && !ld_n;
    assign rcnt      = wbin_r - rbin;
    assign mem_raddr = rbin[AW-1:0];

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_go) begin
            rbin  <= rbin + 1'b1;
            rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
        end
    end

    dcf_ofs_seq u_rb_seq (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .step  (rb_go),
        .sel   (rb_sel)
    );

    always_comb begin
        unique case (rb_sel)
            OFS_AE: rb_val = ae_ofs;
            OFS_AF: rb_val = af_ofs;
        endcase
    end

    // Output register: a stored word on a read, a threshold on a read-back.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_go) rd_q <= mem_rdata;
        else if (rb_go) rd_q <= {{(DW-AW){1'b0}}, rb_val};
    end

    // Registered almost-empty flag, in the read domain.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) ae_q <= 1'b1;
        else        ae_q <= (rcnt <= {1'b0, ae_ofs});
    end
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              ld_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    localparam int          PW       = ADDR_W + 1;
    localparam int          DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL_CNT = PW'(DEPTH);
    localparam logic [ADDR_W:0] HALF_CNT = PW'(DEPTH / 2);

    logic [ADDR_W:0]   wbin, wgray, rbin, rgray;
    logic [ADDR_W:0]   wgray_rs, rgray_ws;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata, rd_q;
    logic [ADDR_W-1:0] ae_ofs, af_ofs;
    logic              full, empty, af_q, ae_q;
    logic [ADDR_W:0]   cnt_live, free_live;
    logic              ae_live, af_live;

    dcf_wr_side #(.AW(ADDR_W), .DW(DATA_W)) u_wr (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .wr_en_n    (wr_en_n),
        .ld_n       (ld_n),
        .wr_data    (wr_data),
        .rgray_sync (rgray_ws),
        .wbin       (wbin),
        .wgray      (wgray),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .full       (full),
        .ae_ofs     (ae_ofs),
        .af_ofs     (af_ofs),
        .af_q       (af_q)
    );

    dcf_rd_side #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .rd_en_n    (rd_en_n),
        .ld_n       (ld_n),
        .wgray_sync (wgray_rs),
        .mem_rdata  (mem_rdata),
        .ae_ofs     (ae_ofs),
        .af_ofs     (af_ofs),
        .rbin       (rbin),
        .rgray      (rgray),
        .mem_raddr  (mem_raddr),
        .empty      (empty),
        .ae_q       (ae_q),
        .rd_q       (rd_q)
    );

    dcf_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcf_sync2 #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    dcf_sync2 #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    // Live fill level taken from both positions, with no synchronizer delay.
    assign cnt_live  = wbin - rbin;
    assign free_live = FULL_CNT - cnt_live;
    assign ae_live   = (cnt_live <= {1'b0, ae_ofs});
    assign af_live   = (free_live <= {1'b0, af_ofs});

    assign empty_n        = ~empty;
    assign full_n         = ~full;
    assign half_full_n    = ~(cnt_live > HALF_CNT);
    assign almost_empty_n = ~(sync_mode ? ae_q : ae_live);
    assign almost_full_n  = ~(sync_mode ? af_q : af_live);

    assign rd_oe   = ~out_en_n;
    assign rd_data = out_en_n ? '0 : rd_q;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          ld_n,
    input logic          out_en_n,
    input logic          full_n,
    input logic          empty_n,
    input logic [DW-1:0] rd_data,
    input logic          rd_oe,
    input logic [AW:0]   wbin,
    input logic [AW:0]   rbin
);
    localparam int PW = AW + 1;
    localparam logic [AW:0] FULL_CNT = PW'(1 << AW);

    // R1: a write attempt on a full buffer leaves the write position unchanged
    p_no_overflow_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en_n) |=> $stable(wbin));

    // R1: an accepted write advances the write position by one
    p_write_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full_n && !wr_en_n && ld_n) |=> (wbin == $past(wbin) + 1'b1));

    // R2: a read attempt on an empty buffer leaves the read position unchanged
    p_no_underflow_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && !rd_en_n) |=> $stable(rbin));

    // R3: threshold loads do not touch the write position
    p_load_holds_wptr_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !ld_n |=> $stable(wbin));

    // R4: threshold read-backs do not touch the read position
    p_readback_holds_rptr_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !ld_n |=> $stable(rbin));

    // R5: the fill level never exceeds the depth
    p_fill_bound_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ((wbin - rbin) <= FULL_CNT));

    // R9: a disabled output shows zeros and no valid strobe
    p_oe_gate_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        out_en_n |-> (rd_data == '0 && !rd_oe));
endmodule

bind dcfifo_pflags dcf_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .wr_en_n  (wr_en_n),
    .rd_en_n  (rd_en_n),
    .ld_n     (ld_n),
    .out_en_n (out_en_n),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .rd_data  (rd_data),
    .rd_oe    (rd_oe),
    .wbin     (wbin),
    .rbin     (rbin)
);

// File: tb/tb_dcfifo_pflags.sv
`timescale 1ns/1ps
module tb_dcfifo_pflags;
    localparam int AW    = 4;
    localparam int DW    = 18;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_mode = 1'b1;
    logic          ld_n = 1'b1;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_oe, empty_n, full_n, half_full_n, almost_empty_n, almost_full_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [DW-1:0] model_q[$];
    int ae_t = DEPTH / 8;
    int af_t = DEPTH / 8;

    always #4 wr_clk = ~wr_clk;   // 125 MHz
    always #5 rd_clk = ~rd_clk;

    dcfifo_pflags #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .ld_n(ld_n), .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .out_en_n(out_en_n), .rd_data(rd_data), .rd_oe(rd_oe), .empty_n(empty_n),
        .full_n(full_n), .half_full_n(half_full_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n)
    );

    function automatic logic exp_ae_n(int cnt, int ofs);
        return (cnt <= ofs) ? 1'b0 : 1'b1;
    endfunction
    function automatic logic exp_af_n(int cnt, int ofs);
        return ((DEPTH - cnt) <= ofs) ? 1'b0 : 1'b1;
    endfunction
    function automatic logic exp_hf_n(int cnt);
        return (cnt > DEPTH / 2) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic settle();
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic do_write(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_data = d;
        wr_en_n = 1'b0;
        if (full_n) model_q.push_back(d);
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic do_load(input logic [DW-1:0] d);
        @(negedge wr_clk);
        ld_n = 1'b0; wr_data = d; wr_en_n = 1'b0;
        @(negedge wr_clk);
        ld_n = 1'b1; wr_en_n = 1'b1;
    endtask

    task automatic do_readback(output logic [DW-1:0] v);
        @(negedge rd_clk);
        ld_n = 1'b0; rd_en_n = 1'b0;
        @(negedge rd_clk);
        ld_n = 1'b1; rd_en_n = 1'b1;
        v = rd_data;
    endtask

    task automatic do_read(output logic [DW-1:0] v, output bit took);
        @(negedge rd_clk);
        took = empty_n;
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        v = rd_data;
    endtask

    task automatic check_flags(input string tag);
        int c = model_q.size();
        chk({tag, " R5 empty_n"}, 32'(empty_n), 32'(c != 0));
        chk({tag, " R5 full_n"}, 32'(full_n), 32'(c != DEPTH));
        chk({tag, " R8 half_full_n"}, 32'(half_full_n), 32'(exp_hf_n(c)));
        chk({tag, " R6 almost_empty_n"}, 32'(almost_empty_n), 32'(exp_ae_n(c, ae_t)));
        chk({tag, " R6 almost_full_n"}, 32'(almost_full_n), 32'(exp_af_n(c, af_t)));
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, all requirements unfinished");
        report();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] last;
        bit took;
        void'($urandom(32'd20240611));
        #41 rst_n = 1'b1;
        @(negedge wr_clk);

        // R10: reset state and default thresholds
        check_flags("R10 reset");
        do_readback(v); chk("R10 R4 default AE readback", 32'(v), 32'(DEPTH / 8));
        do_readback(v); chk("R10 R4 default AF readback", 32'(v), 32'(DEPTH / 8));

        // R3: load AE then AF; R4: read back in the same order
        do_load(18'h3ff03); ae_t = 3;
        do_load(18'h3ff05); af_t = 5;
        do_readback(v); chk("R4 AE readback", 32'(v), 32'd3);
        do_readback(v); chk("R4 AF readback", 32'(v), 32'd5);
        settle();
        chk("R3 load leaves buffer empty", 32'(empty_n), 32'd0);

        // Fill to 3, then cross the almost-empty threshold in sync mode (R7)
        for (int i = 0; i < 3; i++) do_write(18'h100 + 18'(i));
        settle(); check_flags("count3");
        do_write(18'h103);
        chk("R7 sync AE still old", 32'(almost_empty_n), 32'd0);
        settle(); check_flags("count4");

        // Decoded mode
        sync_mode = 1'b0;
        for (int i = 4; i < 8; i++) do_write(18'h100 + 18'(i));
        settle(); check_flags("count8");
        do_write(18'h108);
        chk("R8 half_full immediate", 32'(half_full_n), 32'd0);
        do_write(18'h109);
        chk("R7 async AF at 10", 32'(almost_full_n), 32'd1);
        do_write(18'h10a);
        chk("R7 async AF immediate", 32'(almost_full_n), 32'd0);
        for (int i = 11; i < DEPTH; i++) do_write(18'h100 + 18'(i));
        chk("R5 full_n after last write", 32'(full_n), 32'd0);
        do_write(18'h3ffff);
        chk("R1 write on full dropped", 32'(model_q.size()), 32'(DEPTH));
        settle(); check_flags("full");

        // R9: output enable gating
        out_en_n = 1'b1; #1;
        chk("R9 data gated", 32'(rd_data), 32'd0);
        chk("R9 oe low", 32'(rd_oe), 32'd0);
        out_en_n = 1'b0; #1;
        chk("R9 oe high", 32'(rd_oe), 32'd1);
        chk("R9 held word", 32'(rd_data), 32'd5);

        // Drain in decoded mode with per-read flag checks (R2, R7, R8)
        for (int i = 0; i < DEPTH; i++) begin
            do_read(v, took);
            last = model_q.pop_front();
            chk("R2 drain order", 32'(v), 32'(last));
            chk("R7 async AE", 32'(almost_empty_n), 32'(exp_ae_n(model_q.size(), ae_t)));
            chk("R8 half_full", 32'(half_full_n), 32'(exp_hf_n(model_q.size())));
        end
        chk("R5 empty_n after drain", 32'(empty_n), 32'd0);
        do_read(v, took);
        chk("R2 read on empty ignored", 32'(v), 32'(last));

        // Random traffic in sync mode
        sync_mode = 1'b1;
        settle();
        fork
            begin
                for (int i = 0; i < 400; i++) begin
                    @(negedge wr_clk);
                    if ($urandom % 100 < 55) begin
                        wr_data = 18'($urandom);
                        wr_en_n = 1'b0;
                        if (full_n) model_q.push_back(wr_data);
                    end else begin
                        wr_en_n = 1'b1;
                    end
                end
                @(negedge wr_clk); wr_en_n = 1'b1;
            end
            begin
                bit pend = 0;
                logic [DW-1:0] e;
                for (int i = 0; i < 330; i++) begin
                    @(negedge rd_clk);
                    if (pend) begin
                        e = model_q.pop_front();
                        chk("R1 R2 random order", 32'(rd_data), 32'(e));
                    end
                    pend = ($urandom % 100 < 55) && empty_n;
                    rd_en_n = pend ? 1'b0 : 1'b1;
                end
                @(negedge rd_clk);
                rd_en_n = 1'b1;
                if (pend) begin
                    e = model_q.pop_front();
                    chk("R1 R2 random order", 32'(rd_data), 32'(e));
                end
            end
        join
        settle();
        check_flags("random end");
        for (int i = 0; i < DEPTH + 2 && model_q.size() > 0; i++) begin
            do_read(v, took);
            last = model_q.pop_front();
            chk("R2 final drain", 32'(v), 32'(last));
        end
        settle();
        check_flags("final");
        done = 1;
        report();
        $finish;
    end
endmodule